// File: doc/BRIEF.md
# Pixel Bit-Depth Reduction Formatter

This block sits between the pixel pipeline and the link encoder. It takes 12-bit-per-channel RGB pixels as a valid stream with a frame-start flag. It cuts each channel down to 6 or 8 significant bits, by rounding truncation or by spatial random dithering, and then applies range clamping. The result stays MSB-aligned in the 12-bit domain.

The dither noise comes from one 28-bit LFSR per channel. All three channels can share the tap set x^28+x^3+1, or each can use its own tap set. Each LFSR is loaded from its own seed on the first pixel after reset. It can also be reloaded at every frame start, and a 4-bit frame count is mixed into the seed so that consecutive frames get different noise.

The clamp stage is selected by a format code. It applies the fixed limited-range bounds or a pair of programmable bounds. The configuration inputs are expected to stay static while pixels flow. The reduction settings are sampled with each input pixel, and the clamp settings one cycle later.

Top module: `pix_depth_fmt`

## Requirements
- R1: While reset is asserted and after its release until the first pixel, out_valid and out_sof are 0 and out_r, out_g, out_b are 0.
- R2: Every pixel accepted with pix_valid=1 appears on the outputs exactly two clock cycles later with out_valid=1 and its start flag on out_sof. Back-to-back pixels stay in order, and out_valid is 0 in cycles that carry no pixel. With reduction and clamping off, the data is unchanged.
- R3: A depth code of 0 keeps 6 bits (clears the low 6 bits) and a code of 1 keeps 8 bits (clears the low 4). A depth code of 2 or 3 leaves that reduction disabled even when it is enabled.
- R4: Truncation adds half of one kept LSB (32 for depth 0, 8 for depth 1), saturates at 4095 and then clears the discarded bits. 0xFFF becomes 0xFC0 at depth 0 and 0xFF0 at depth 1.
- R5: Dithering adds the low bits of the channel's current LFSR value, as many bits as are discarded, then saturates and clears like R4. When dithering is in effect it takes precedence over truncation.
- R6: Each LFSR is 28 bits and steps once per accepted pixel, shifting left and inserting bit27 XOR bit(k-1) at bit 0. With chan_poly=0, k=3 for all channels. With chan_poly=1, k is 3 for red, 9 for green and 13 for blue. The value used by a pixel is the value before its step.
- R7: The first pixel after reset uses its channel seed as LFSR value. With frame_reseed=1, every pixel with pix_sof=1 uses seed XOR frame count (count in the low 4 bits). With frame_reseed=0, a start flag does not reload.
- R8: The frame count advances on each start-flag pixel while frame_reseed=1. It wraps from 15 to 0 and is held at 0 while frame_reseed=0.
- R9: Clamp code 0 and codes 4 to 6 do not clamp. Codes 1, 2 and 3 limit each channel to [256, 3760]. Code 7 limits to [clamp_lo, clamp_hi]. Clamping applies to the reduced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trunc_en | input | 1 | Truncation enable |
| trunc_depth | input | 2 | Truncation depth code |
| dith_en | input | 1 | Spatial dither enable |
| dith_depth | input | 2 | Dither depth code |
| chan_poly | input | 1 | 1 = per-channel tap sets, 0 = shared |
| frame_reseed | input | 1 | Reload LFSRs at every frame start |
| seed_r | input | 28 | Red LFSR seed |
| seed_g | input | 28 | Green LFSR seed |
| seed_b | input | 28 | Blue LFSR seed |
| clamp_fmt | input | 3 | Clamp format code |
| clamp_lo | input | 12 | Programmable lower bound |
| clamp_hi | input | 12 | Programmable upper bound |
| pix_valid | input | 1 | Input pixel valid |
| pix_sof | input | 1 | Input pixel is first of frame |
| pix_r | input | 12 | Input red |
| pix_g | input | 12 | Input green |
| pix_b | input | 12 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output first-of-frame flag |
| out_r | output | 12 | Output red |
| out_g | output | 12 | Output green |
| out_b | output | 12 | Output blue |

## Verification
The hardest situation to reach from the ports is the frame count wrapping from 15 back to 0 while reseeding is on. It can only be seen through the dither noise of a start-flag pixel 16 frames later. The stimulus sends runs of more than sixteen start-flag pixels with ordinary pixels between them. It then turns reseeding off and on again. A bench-side model of the LFSRs, the seeding and the count predicts every output, and input values with varied low bits make the noise visible after clearing. A mid-run reset checks that the first pixel after reset loads the seed.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
  localparam int unsigned NUM_CH = 3;

  typedef enum logic [1:0] {
    DEP_6B  = 2'd0,
    DEP_8B  = 2'd1,
    DEP_10B = 2'd2,
    DEP_RSV = 2'd3
  } depth_code_e;

  typedef enum logic [2:0] {
    CLP_OFF  = 3'd0,
    CLP_8B   = 3'd1,
    CLP_10B  = 3'd2,
    CLP_12B  = 3'd3,
    CLP_PROG = 3'd7
  } clamp_code_e;

  // Only the 6- and 8-bit output depths are supported
  function automatic logic depth_ok(input logic [1:0] d);
    return (d == DEP_6B) || (d == DEP_8B);
  endfunction
endpackage

// File: rtl/pdf_lfsr.sv
module pdf_lfsr #(
  parameter int unsigned W       = 28,
  parameter int unsigned TAP_SHR = 3,
  parameter int unsigned TAP_OWN = 3,
  parameter int unsigned NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               load,
  input  logic               own_poly,
  input  logic [W-1:0]       load_val,
  output logic [NOISE_W-1:0] noise
);
  logic [W-1:0] state_q, state_d, cur;
  logic         fb;

  always_comb begin
    cur     = load ? load_val : state_q;
    fb      = cur[W-1] ^ (own_poly ? cur[TAP_OWN-1] : cur[TAP_SHR-1]);
    state_d = state_q;
    if (adv) state_d = {cur[W-2:0], fb};
    noise   = cur[NOISE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  // R6: a non-zero value never collapses to the all-zero lock-up state
  a_r6_keeps_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (cur != '0)) |=> (state_q != '0));
  // R6: no step without an accepted pixel
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> (state_q == $past(state_q)));
endmodule

// File: rtl/pdf_reduce.sv
module pdf_reduce #(
  parameter int unsigned PIX_W     = 12,
  parameter int unsigned KEEP_NARR = 6,
  parameter int unsigned KEEP_WIDE = 8,
  parameter int unsigned NOISE_W   = PIX_W - KEEP_NARR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   x,
  input  logic [NOISE_W-1:0] noise,
  input  logic               dith_on,
  input  logic               trunc_on,
  input  logic               keep_wide,
  output logic [PIX_W-1:0]   y
);
  localparam int unsigned SH_W   = $clog2(PIX_W + 1);
  localparam int unsigned DROP_N = PIX_W - KEEP_NARR;
  localparam int unsigned DROP_W = PIX_W - KEEP_WIDE;

  logic [SH_W-1:0]  drop;
  logic [PIX_W-1:0] low_mask, addend, sat;
  logic [PIX_W:0]   sum;
  logic             active;

  always_comb begin
    drop     = keep_wide ? SH_W'(DROP_W) : SH_W'(DROP_N);
    low_mask = (PIX_W'(1) << drop) - PIX_W'(1);
    active   = dith_on | trunc_on;
    if (dith_on)       addend = PIX_W'(noise) & low_mask;
    else if (trunc_on) addend = PIX_W'(1) << (drop - SH_W'(1));
    else               addend = '0;
    sum = {1'b0, x} + {1'b0, addend};
    sat = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
    y   = active ? (sat & ~low_mask) : x;
  end

  // R4/R5: result lies within one kept step of the input
  a_r4_within_step: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((({1'b0, y} + {1'b0, low_mask} + (PIX_W+1)'(1)) > {1'b0, x}) &&
                ({1'b0, y} <= ({1'b0, x} + {1'b0, low_mask} + (PIX_W+1)'(1)))));
  // R3: inactive reduction leaves the value alone
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (y == x));
endmodule

// File: rtl/pdf_clamp.sv
module pdf_clamp
  import pdf_pkg::*;
#(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned FIX_LO = 256,
  parameter int unsigned FIX_HI = 3760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] x,
  input  logic [2:0]       fmt,
  input  logic [PIX_W-1:0] prog_lo,
  input  logic [PIX_W-1:0] prog_hi,
  output logic [PIX_W-1:0] y
);
  logic [PIX_W-1:0] lo_c, hi_c;
  logic             on_c;

  always_comb begin
    on_c = 1'b0;
    lo_c = '0;
    hi_c = '1;
    case (fmt)
      CLP_8B, CLP_10B, CLP_12B: begin
        on_c = 1'b1;
        lo_c = PIX_W'(FIX_LO);
        hi_c = PIX_W'(FIX_HI);
      end
      CLP_PROG: begin
        on_c = 1'b1;
        lo_c = prog_lo;
        hi_c = prog_hi;
      end
      default: on_c = 1'b0;
    endcase
    if (!on_c)          y = x;
    else if (x < lo_c)  y = lo_c;
    else if (x > hi_c)  y = hi_c;
    else                y = x;
  end

  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && (lo_c <= hi_c)) |-> ((y >= lo_c) && (y <= hi_c)));
  a_r9_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !on_c |-> (y == x));
endmodule

// File: rtl/pix_depth_fmt.sv
module pix_depth_fmt
  import pdf_pkg::*;
#(
  parameter int unsigned PIX_W     = 12,
  parameter int unsigned LFSR_W    = 28,
  parameter int unsigned KEEP_NARR = 6,
  parameter int unsigned KEEP_WIDE = 8,
  parameter int unsigned TAP_SHR   = 3,
  parameter int unsigned TAP_RED   = 3,
  parameter int unsigned TAP_GRN   = 9,
  parameter int unsigned TAP_BLU   = 13,
  parameter int unsigned FRAME_MAX = 15,
  parameter int unsigned FIX_LO    = 256,
  parameter int unsigned FIX_HI    = 3760
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trunc_en,
  input  logic [1:0]        trunc_depth,
  input  logic              dith_en,
  input  logic [1:0]        dith_depth,
  input  logic              chan_poly,
  input  logic              frame_reseed,
  input  logic [LFSR_W-1:0] seed_r,
  input  logic [LFSR_W-1:0] seed_g,
  input  logic [LFSR_W-1:0] seed_b,
  input  logic [2:0]        clamp_fmt,
  input  logic [PIX_W-1:0]  clamp_lo,
  input  logic [PIX_W-1:0]  clamp_hi,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic [PIX_W-1:0]  pix_r,
  input  logic [PIX_W-1:0]  pix_g,
  input  logic [PIX_W-1:0]  pix_b,
  output logic              out_valid,
  output logic              out_sof,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  localparam int unsigned CNT_W   = $clog2(FRAME_MAX + 1);
  localparam int unsigned NOISE_W = PIX_W - KEEP_NARR;

  logic dith_on_c, trunc_on_c, keep_wide_c, load_c;
  logic started_q, started_d;
  logic [CNT_W-1:0]  fcnt_q, fcnt_d;
  logic [LFSR_W-1:0] reseed_mix;

  logic [NUM_CH-1:0][LFSR_W-1:0] seed_c;
  logic [NUM_CH-1:0][PIX_W-1:0]  pix_c, red_c, clp_c;

  logic                          s1_valid_q, s1_valid_d, s1_sof_q, s1_sof_d;
  logic [NUM_CH-1:0][PIX_W-1:0]  s1_pix_q, s1_pix_d;
  logic                          o_valid_q, o_valid_d, o_sof_q, o_sof_d;
  logic [NUM_CH-1:0][PIX_W-1:0]  o_pix_q, o_pix_d;

  assign seed_c = {seed_b, seed_g, seed_r};
  assign pix_c  = {pix_b, pix_g, pix_r};

  // Mode decode: unsupported depth codes leave a function off
  always_comb begin
    dith_on_c   = dith_en & depth_ok(dith_depth);
    trunc_on_c  = trunc_en & depth_ok(trunc_depth) & ~dith_on_c;
    keep_wide_c = dith_on_c ? dith_depth[0] : trunc_depth[0];
  end

  // Seeding control and frame counter
  always_comb begin
    load_c     = pix_valid & (~started_q | (pix_sof & frame_reseed));
    reseed_mix = frame_reseed ? LFSR_W'(fcnt_q) : '0;
    started_d  = started_q | pix_valid;
    if (!frame_reseed)
      fcnt_d = '0;
    else if (pix_valid && pix_sof)
      fcnt_d = (fcnt_q == CNT_W'(FRAME_MAX)) ? '0 : fcnt_q + CNT_W'(1);
    else
      fcnt_d = fcnt_q;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned TAP_CH = (c == 0) ? TAP_RED : (c == 1) ? TAP_GRN : TAP_BLU;
    logic [NOISE_W-1:0] noise_c;

    pdf_lfsr #(.W(LFSR_W), .TAP_SHR(TAP_SHR), .TAP_OWN(TAP_CH), .NOISE_W(NOISE_W)) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (pix_valid),
      .load     (load_c),
      .own_poly (chan_poly),
      .load_val (seed_c[c] ^ reseed_mix),
      .noise    (noise_c)
    );

    pdf_reduce #(.PIX_W(PIX_W), .KEEP_NARR(KEEP_NARR), .KEEP_WIDE(KEEP_WIDE), .NOISE_W(NOISE_W)) u_reduce (
      .clk       (clk),
      .rst_n     (rst_n),
      .x         (pix_c[c]),
      .noise     (noise_c),
      .dith_on   (dith_on_c),
      .trunc_on  (trunc_on_c),
      .keep_wide (keep_wide_c),
      .y         (red_c[c])
    );

    pdf_clamp #(.PIX_W(PIX_W), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)) u_clamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .x       (s1_pix_q[c]),
      .fmt     (clamp_fmt),
      .prog_lo (clamp_lo),
      .prog_hi (clamp_hi),
      .y       (clp_c[c])
    );
  end

  // Pipeline next state with explicit data enables
  always_comb begin
    s1_valid_d = pix_valid;
    s1_sof_d   = pix_valid & pix_sof;
    s1_pix_d   = s1_pix_q;
    if (pix_valid) s1_pix_d = red_c;
    o_valid_d  = s1_valid_q;
    o_sof_d    = s1_sof_q;
    o_pix_d    = o_pix_q;
    if (s1_valid_q) o_pix_d = clp_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      fcnt_q     <= '0;
      s1_valid_q <= 1'b0;
      s1_sof_q   <= 1'b0;
      s1_pix_q   <= '0;
      o_valid_q  <= 1'b0;
      o_sof_q    <= 1'b0;
      o_pix_q    <= '0;
    end else begin
      started_q  <= started_d;
      fcnt_q     <= fcnt_d;
      s1_valid_q <= s1_valid_d;
      s1_sof_q   <= s1_sof_d;
      s1_pix_q   <= s1_pix_d;
      o_valid_q  <= o_valid_d;
      o_sof_q    <= o_sof_d;
      o_pix_q    <= o_pix_d;
    end
  end

  assign out_valid = o_valid_q;
  assign out_sof   = o_sof_q;
  assign out_r     = o_pix_q[0];
  assign out_g     = o_pix_q[1];
  assign out_b     = o_pix_q[2];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_q |=> !out_valid);
  a_r2_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= CNT_W'(FRAME_MAX));
  a_r8_cnt_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_reseed |=> (fcnt_q == '0));
  a_r7_started_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> started_q);
endmodule

// File: tb/pix_depth_fmt_tb.sv
module pix_depth_fmt_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic t_en, d_en, cpoly, frs;
  logic [1:0] t_dep, d_dep;
  logic [27:0] sd [3];
  logic [2:0] cfmt;
  logic [11:0] clo, chi;
  logic pv, psof;
  logic [11:0] pr, pg, pb;
  logic ov, osof;
  logic [11:0] orr, og, ob;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [27:0] m_st [3];
  bit m_started;
  int m_cnt;

  always #5 clk = ~clk;

  pix_depth_fmt u_dut (
    .clk(clk), .rst_n(rst_n),
    .trunc_en(t_en), .trunc_depth(t_dep), .dith_en(d_en), .dith_depth(d_dep),
    .chan_poly(cpoly), .frame_reseed(frs),
    .seed_r(sd[0]), .seed_g(sd[1]), .seed_b(sd[2]),
    .clamp_fmt(cfmt), .clamp_lo(clo), .clamp_hi(chi),
    .pix_valid(pv), .pix_sof(psof), .pix_r(pr), .pix_g(pg), .pix_b(pb),
    .out_valid(ov), .out_sof(osof), .out_r(orr), .out_g(og), .out_b(ob)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [27:0] lnext(input logic [27:0] q, input int k);
    return {q[26:0], q[27] ^ q[k-1]};
  endfunction

  function automatic int ref_red(input int x, input int nz, input bit don, input bit ton, input bit wide);
    int drop = wide ? 4 : 6;
    int mask = (1 << drop) - 1;
    int s;
    if (don)      s = x + (nz & mask);
    else if (ton) s = x + (1 << (drop - 1));
    else          return x;
    if (s > 4095) s = 4095;
    return s & ~mask & 12'hFFF;
  endfunction

  function automatic int ref_clamp(input int x);
    int lo, hi;
    if (cfmt == 3'd1 || cfmt == 3'd2 || cfmt == 3'd3) begin lo = 256; hi = 3760; end
    else if (cfmt == 3'd7) begin lo = int'(clo); hi = int'(chi); end
    else return x;
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  task automatic model_px(input int x [3], input bit sof, output int ex [3]);
    bit don, ton, wide, ld;
    logic [27:0] cur;
    int k;
    don  = d_en && (d_dep < 2);
    ton  = t_en && (t_dep < 2) && !don;
    wide = don ? d_dep[0] : t_dep[0];
    if (!frs) m_cnt = 0;
    ld = !m_started || (sof && frs);
    for (int c = 0; c < 3; c++) begin
      cur = ld ? (sd[c] ^ (frs ? 28'(m_cnt) : 28'd0)) : m_st[c];
      k = !cpoly ? 3 : (c == 0) ? 3 : (c == 1) ? 9 : 13;
      ex[c] = ref_clamp(ref_red(x[c], int'(cur[5:0]), don, ton, wide));
      m_st[c] = lnext(cur, k);
    end
    m_started = 1;
    if (sof && frs) m_cnt = (m_cnt == 15) ? 0 : m_cnt + 1;
  endtask

  task automatic drive(input int x [3], input bit sof);
    pv = 1'b1; psof = sof;
    pr = 12'(x[0]); pg = 12'(x[1]); pb = 12'(x[2]);
  endtask

  task automatic idle_in();
    pv = 1'b0; psof = 1'b0;
  endtask

  task automatic chk_out(input string tag, input int ex [3], input bit sof);
    chk({tag, " valid"}, int'(ov), 1);
    chk({tag, " sof"}, int'(osof), int'(sof));
    chk({tag, " r"}, int'(orr), ex[0]);
    chk({tag, " g"}, int'(og), ex[1]);
    chk({tag, " b"}, int'(ob), ex[2]);
  endtask

  // one isolated pixel, checked two cycles after acceptance
  task automatic px(input string tag, input int r, input int g, input int b, input bit sof);
    int x [3];
    int ex [3];
    x[0] = r; x[1] = g; x[2] = b;
    model_px(x, sof, ex);
    @(negedge clk) drive(x, sof);
    @(negedge clk) idle_in();
    @(negedge clk) chk_out(tag, ex, sof);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_in();
    repeat (3) @(negedge clk);
    for (int c = 0; c < 3; c++) m_st[c] = '0;
    m_started = 0; m_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic cfg_off();
    t_en = 0; t_dep = 0; d_en = 0; d_dep = 0; cpoly = 0; frs = 0; cfmt = 0;
  endtask

  task automatic t_reset();
    // R1
    chk("R1 reset valid", int'(ov), 0);
    chk("R1 reset sof", int'(osof), 0);
    chk("R1 reset data", int'(orr | og | ob), 0);
    @(negedge clk);
    chk("R1 idle valid", int'(ov), 0);
  endtask

  task automatic t_stream();
    int a [3], b [3], ea [3], eb [3];
    cfg_off();
    a[0] = 12'hABC; a[1] = 12'h123; a[2] = 12'hFFF;
    b[0] = 12'h001; b[1] = 12'h800; b[2] = 12'h7FF;
    model_px(a, 1, ea);
    model_px(b, 0, eb);
    @(negedge clk) drive(a, 1);
    chk("R2 not early", int'(ov), 0);
    @(negedge clk) drive(b, 0);
    chk("R2 not early 2", int'(ov), 0);
    @(negedge clk) idle_in();
    chk_out("R2 first", ea, 1);
    @(negedge clk) chk_out("R2 second", eb, 0);
    @(negedge clk) chk("R2 gap valid", int'(ov), 0);
  endtask

  task automatic t_depth();
    cfg_off();
    t_en = 1; t_dep = 0;
    px("R3 depth0", 12'h7C5, 12'h03F, 12'hA81, 0);
    t_dep = 1;
    px("R3 depth1", 12'h7C5, 12'h03F, 12'hA81, 0);
    t_dep = 2;
    px("R3 depth2 off", 12'h7C5, 12'h03F, 12'hA81, 0);
    t_dep = 3;
    px("R3 depth3 off", 12'h7DF, 12'h001, 12'hFFF, 0);
  endtask

  task automatic t_round();
    cfg_off();
    t_en = 1; t_dep = 0;
    px("R4 round up d0", 12'h7E0, 12'h7DF, 12'hFFF, 0);
    t_dep = 1;
    px("R4 round up d1", 12'h7F8, 12'h7F7, 12'hFFF, 0);
  endtask

  task automatic t_dither();
    cfg_off();
    sd[0] = 28'h5A5A5A5; sd[1] = 28'h0F1E2D3; sd[2] = 28'h7654321;
    d_en = 1; d_dep = 0;
    for (int i = 0; i < 20; i++)
      px("R5 dither d0", 12'h400 + i*13, 12'h123 + i*29, 12'hC00 + i*7, 0);
    d_dep = 1;
    for (int i = 0; i < 12; i++)
      px("R5 dither d1", 12'h405 + i*5, 12'h2F3 + i*3, 12'h9A1 + i*11, 0);
    px("R5 saturate", 12'hFFF, 12'hFFF, 12'hFFF, 0);
    t_en = 1; t_dep = 1; d_dep = 0;
    for (int i = 0; i < 6; i++)
      px("R5 precedence", 12'h3A7 + i*9, 12'h555 + i, 12'h0F0 + i*17, 0);
    d_dep = 2; t_dep = 0;
    px("R5 dither depth2 falls to trunc", 12'h7DF, 12'h020, 12'h3C1, 0);
  endtask

  task automatic t_poly();
    cfg_off();
    sd[0] = 28'h9C3A5E1; sd[1] = 28'h9C3A5E1; sd[2] = 28'h9C3A5E1;
    d_en = 1; d_dep = 0;
    for (int i = 0; i < 10; i++)
      px("R6 shared taps", 12'h420 + i*3, 12'h420 + i*3, 12'h420 + i*3, 0);
    cpoly = 1;
    for (int i = 0; i < 24; i++)
      px("R6 own taps", 12'h420 + i*3, 12'h420 + i*3, 12'h420 + i*3, 0);
  endtask

  task automatic t_seed();
    cfg_off();
    sd[0] = 28'h000003F; sd[1] = 28'h0000020; sd[2] = 28'h0000011;
    do_reset();
    d_en = 1; d_dep = 0;
    px("R7 first after reset", 12'h401, 12'h41F, 12'h42E, 0);
    px("R7 second", 12'h401, 12'h41F, 12'h42E, 0);
    px("R7 sof no reload", 12'h401, 12'h41F, 12'h42E, 1);
    frs = 1;
    px("R7 sof reload", 12'h401, 12'h41F, 12'h42E, 1);
    px("R7 after reload", 12'h401, 12'h41F, 12'h42E, 0);
    px("R7 reload count1", 12'h401, 12'h41F, 12'h42E, 1);
  endtask

  task automatic t_frame();
    cfg_off();
    sd[0] = 28'h1234560; sd[1] = 28'h0ABCDE0; sd[2] = 28'h7000000;
    d_en = 1; d_dep = 0; frs = 1;
    for (int f = 0; f < 19; f++) begin
      px("R8 frame start", 12'h430 + f, 12'h421, 12'h43F, 1);
      px("R8 frame body", 12'h410, 12'h43E, 12'h41C, 0);
    end
    frs = 0;
    px("R8 count held", 12'h430, 12'h421, 12'h43F, 1);
    frs = 1;
    px("R8 restart at zero", 12'h430, 12'h421, 12'h43F, 1);
    px("R8 next count", 12'h430, 12'h421, 12'h43F, 1);
  endtask

  task automatic t_clamp();
    cfg_off();
    clo = 12'h010; chi = 12'hFEF;
    for (int f = 0; f < 8; f++) begin
      cfmt = 3'(f);
      px("R9 clamp", 12'h050, 12'hFFF, 12'h800, 0);
      px("R9 clamp edge", 12'h0FF, 12'hEB1, 12'h100, 0);
    end
    cfmt = 3'd7;
    px("R9 prog low", 12'h005, 12'h010, 12'hFF0, 0);
    t_en = 1; t_dep = 0;
    px("R9 after reduction", 12'hFFF, 12'h00F, 12'h7E0, 0);
    clo = 12'h300; chi = 12'h200;
    px("R9 prog crossed", 12'h100, 12'h250, 12'h400, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_off();
    sd[0] = 28'h1; sd[1] = 28'h2; sd[2] = 28'h3;
    clo = 12'h010; chi = 12'hFEF;
    pr = 0; pg = 0; pb = 0;
    rst_n = 1'b0;
    idle_in();
    #1;
    do_reset();
    t_reset();
    t_stream();
    t_depth();
    t_round();
    t_dither();
    t_poly();
    t_seed();
    t_frame();
    t_clamp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule